// File: doc/BRIEF.md
# Sixteen-Bit Adder with Condition Keys

This unit adds two 16-bit operands and a one-bit increment term, and folds the outcome into a 16-bit status word. The increment term lets the same datapath subtract: the caller presents the inverted subtrahend and sets the increment. Four condition bits are produced from each add. These are the carry-out (link), the zero test (equal), the signed ordering (less-than) and the signed-overflow flag (carry). All four replace their positions in the caller's status word in one masked write. The remaining status bits pass through untouched.

A strobe qualifies each operation. The truncated sum and the merged status word are registered on the next clock edge. A one-cycle overflow pulse accompanies that same registered update, so an exception handler sees a consistent result and status before it acts. When no strobe arrives, the outputs hold.

Top module: `key_adder16`

## Requirements
- R1: One cycle after a cycle with `in_valid` high, `sum_out` equals (`op_a` + `op_b` + `carry_in`) modulo 2^16, taken from the strobe cycle, and `out_valid` is high.
- R2: In that update, `keys_out` bit 13 (octal 020000) is bit 16 of the 17-bit sum, i.e. the carry out.
- R3: In that update, `keys_out` bit 6 (octal 0100) is 1 exactly when the 16-bit result is zero.
- R4: Signed overflow is true when `op_a` bit 15 equals `op_b` bit 15 and result bit 15 differs from `op_a` bit 15. `ovf_pulse` is high for exactly the cycle of that update, and only then.
- R5: In that update, `keys_out` bit 7 (octal 0200) equals result bit 15 when there is no overflow, and its inverse when there is overflow.
- R6: In that update, `keys_out` bit 15 (octal 0100000) equals the overflow flag.
- R7: In that update, every `keys_out` bit outside mask octal 0120300 equals the same bit of `keys_in` at the strobe.
- R8: After a cycle with `in_valid` low, `sum_out` and `keys_out` keep their previous values, and `out_valid` and `ovf_pulse` are low.
- R9: While reset is applied, `sum_out`, `keys_out`, `out_valid` and `ovf_pulse` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 16 | First operand; its sign is the reference for overflow |
| op_b | input | 16 | Second operand, inverted by the caller for subtraction |
| carry_in | input | 1 | Increment term added to the sum |
| keys_in | input | 16 | Current status word |
| sum_out | output | 16 | Registered truncated sum |
| keys_out | output | 16 | Registered merged status word |
| out_valid | output | 1 | High in the cycle after a strobe |
| ovf_pulse | output | 1 | One-cycle integer-overflow signal |

## Verification
The assertions assume that the operands, the increment and `keys_in` are settled at the strobe edge. They also assume that strobes after reset begin only once the internal reset release has finished. The stimulus follows both rules. Inputs change only on the falling edge, and the bench waits several cycles after releasing reset before the first strobe. Strobes come both back-to-back and with gaps, so the hold rule is exercised between updates and the comparison against the previous strobe's inputs stays valid.

// File: rtl/key_adder16_pkg.sv
package key_adder16_pkg;
  localparam int KEY_W     = 16;
  localparam int KEY_CARRY = 15;
  localparam int KEY_LINK  = 13;
  localparam int KEY_LT    = 7;
  localparam int KEY_EQ    = 6;
  localparam logic [KEY_W-1:0] KEY_MASK =
    (KEY_W'(1) << KEY_CARRY) | (KEY_W'(1) << KEY_LINK) |
    (KEY_W'(1) << KEY_LT)    | (KEY_W'(1) << KEY_EQ);

  typedef struct packed {
    logic carry;
    logic link;
    logic lt;
    logic eq;
  } cond_t;
endpackage

// File: rtl/kadd_ripple.sv
module kadd_ripple #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic p;
    assign p        = a[i] ^ b[i];
    assign sum[i]   = p ^ c[i];
    assign c[i+1]   = (a[i] & b[i]) | (c[i] & p);
  end

  assign cout = c[W];
endmodule

// File: rtl/kadd_flags.sv
module kadd_flags
  import key_adder16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             a_msb,
  input  logic             b_msb,
  input  logic [W-1:0]     sum,
  input  logic             cout,
  input  logic [KEY_W-1:0] keys_in,
  output logic [KEY_W-1:0] keys_new,
  output logic             ovf
);
  cond_t cond;

  always_comb begin
    cond.link  = cout;
    cond.eq    = (sum == '0);
    cond.carry = (a_msb == b_msb) && (sum[W-1] != a_msb);
    cond.lt    = sum[W-1] ^ cond.carry;
  end

  always_comb begin
    keys_new            = keys_in & ~KEY_MASK;
    keys_new[KEY_CARRY] = cond.carry;
    keys_new[KEY_LINK]  = cond.link;
    keys_new[KEY_LT]    = cond.lt;
    keys_new[KEY_EQ]    = cond.eq;
  end

  assign ovf = cond.carry;
endmodule

// File: rtl/kadd_rst_sync.sv
module kadd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/key_adder16.sv
module key_adder16
  import key_adder16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic             carry_in,
  input  logic [KEY_W-1:0] keys_in,
  output logic [W-1:0]     sum_out,
  output logic [KEY_W-1:0] keys_out,
  output logic             out_valid,
  output logic             ovf_pulse
);
  logic             rst_n_s;
  logic [W-1:0]     sum_c;
  logic             cout_c;
  logic [KEY_W-1:0] keys_c;
  logic             ovf_c;

  logic [W-1:0]     sum_d,  sum_q;
  logic [KEY_W-1:0] keys_d, keys_q;
  logic             vld_d,  vld_q;
  logic             ovf_d,  ovf_q;

  kadd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  kadd_ripple #(.W(W)) u_add (
    .a(op_a), .b(op_b), .cin(carry_in), .sum(sum_c), .cout(cout_c)
  );

  kadd_flags #(.W(W)) u_flags (
    .a_msb(op_a[W-1]), .b_msb(op_b[W-1]), .sum(sum_c), .cout(cout_c),
    .keys_in(keys_in), .keys_new(keys_c), .ovf(ovf_c)
  );

  // next-state
  always_comb begin
    sum_d  = sum_q;
    keys_d = keys_q;
    if (in_valid) begin
      sum_d  = sum_c;
      keys_d = keys_c;
    end
    vld_d = in_valid;
    ovf_d = in_valid & ovf_c;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sum_q  <= '0;
      keys_q <= '0;
      vld_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      keys_q <= keys_d;
      vld_q  <= vld_d;
      ovf_q  <= ovf_d;
    end
  end

  assign sum_out   = sum_q;
  assign keys_out  = keys_q;
  assign out_valid = vld_q;
  assign ovf_pulse = ovf_q;
endmodule

// File: rtl/key_adder16_chk.sv
module key_adder16_chk
  import key_adder16_pkg::*;
#(
  parameter int W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [W-1:0]     op_a,
  input logic [W-1:0]     op_b,
  input logic             carry_in,
  input logic [KEY_W-1:0] keys_in,
  input logic [W-1:0]     sum_out,
  input logic [KEY_W-1:0] keys_out,
  input logic             out_valid,
  input logic             ovf_pulse
);
  logic [W:0] wide;
  assign wide = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};

  p_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> sum_out == $past(wide[W-1:0]));
  p_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> keys_out[KEY_LINK] == $past(wide[W]));
  p_eq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> keys_out[KEY_EQ] == (sum_out == '0));
  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> out_valid);
  p_lt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> keys_out[KEY_LT] == (sum_out[W-1] ^ ovf_pulse));
  p_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> keys_out[KEY_CARRY] == ovf_pulse);
  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (keys_out & ~KEY_MASK) == ($past(keys_in) & ~KEY_MASK));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(sum_out) && $stable(keys_out) && !ovf_pulse);
  always_comb begin
    if (!rst_n) begin
      a_reset_r9: assert (sum_out == '0 && keys_out == '0 && !out_valid && !ovf_pulse);
    end
  end
endmodule

bind key_adder16 key_adder16_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .carry_in(carry_in), .keys_in(keys_in), .sum_out(sum_out),
  .keys_out(keys_out), .out_valid(out_valid), .ovf_pulse(ovf_pulse)
);

// File: tb/key_adder16_tb.sv
`timescale 1ns/1ps
module key_adder16_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] op_a = '0, op_b = '0, keys_in = '0;
  logic        carry_in = 1'b0;
  logic [15:0] sum_out, keys_out;
  logic        out_valid, ovf_pulse;

  int total = 0;
  int bad = 0;
  logic [16:0] exp_q[$];   // {ovf_expected?} packed below
  logic [15:0] exp_sum_q[$];
  logic [15:0] exp_key_q[$];
  logic        exp_ovf_q[$];
  logic [15:0] last_sum = '0, last_key = '0;

  always #2 clk = ~clk;

  key_adder16 u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .keys_in(keys_in), .sum_out(sum_out),
    .keys_out(keys_out), .out_valid(out_valid), .ovf_pulse(ovf_pulse)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // driver: inputs change on falling edge, expected item pushed at once
  task automatic drive(input logic [15:0] a, input logic [15:0] b,
                       input logic ci, input logic [15:0] st);
    logic [16:0] w;
    logic [15:0] r, k;
    logic        ov;
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci; keys_in = st; in_valid = 1'b1;
    w  = {1'b0, a} + {1'b0, b} + {16'd0, ci};
    r  = w[15:0];
    ov = (a[15] == b[15]) && (r[15] != a[15]);
    k  = st & ~16'o120300;
    k[15] = ov; k[13] = w[16]; k[7] = r[15] ^ ov; k[6] = (r == 16'd0);
    exp_sum_q.push_back(r);
    exp_key_q.push_back(k);
    exp_ovf_q.push_back(ov);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = 16'hdead; op_b = 16'hbeef; keys_in = 16'hffff;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      #0.5;
      if (out_valid) begin
        if (exp_sum_q.size() == 0) begin
          check("R1 unexpected out_valid", 16'd1, 16'd0);
        end else begin
          logic [15:0] es, ek;
          logic eo;
          es = exp_sum_q.pop_front();
          ek = exp_key_q.pop_front();
          eo = exp_ovf_q.pop_front();
          check("R1 sum", sum_out, es);
          check("R2 link", {15'd0, keys_out[13]}, {15'd0, ek[13]});
          check("R3 equal", {15'd0, keys_out[6]}, {15'd0, ek[6]});
          check("R4 ovf_pulse", {15'd0, ovf_pulse}, {15'd0, eo});
          check("R5 less-than", {15'd0, keys_out[7]}, {15'd0, ek[7]});
          check("R6 carry", {15'd0, keys_out[15]}, {15'd0, ek[15]});
          check("R7 kept bits", keys_out & ~16'o120300, ek & ~16'o120300);
        end
      end else begin
        check("R8 hold sum", sum_out, last_sum);
        check("R8 hold keys", keys_out, last_key);
        check("R8 no pulse", {15'd0, ovf_pulse}, 16'd0);
      end
      last_sum = sum_out;
      last_key = keys_out;
    end
  end

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset sum", sum_out, 16'd0);
    check("R9 reset keys", keys_out, 16'd0);
    check("R9 reset valid/pulse", {14'd0, out_valid, ovf_pulse}, 16'd0);
    rst_n = 1'b1;
    idle(5);
    // directed corners
    drive(16'h0000, 16'h0000, 1'b0, 16'h0000); // R3 zero
    drive(16'h7fff, 16'h0001, 1'b0, 16'hffff); // R4 positive overflow, R7
    drive(16'h8000, 16'h8000, 1'b0, 16'h5a5a); // R4 negative overflow, R2, R3, R5
    drive(16'hffff, 16'h0000, 1'b1, 16'h0000); // R2 carry with zero result
    idle(3);
    drive(16'h0005, ~16'h0009, 1'b1, 16'h1234); // subtraction 5-9, R5 negative
    drive(16'h0009, ~16'h0005, 1'b1, 16'hedcb); // subtraction 9-5, R2 link
    drive(16'h8000, ~16'h0001, 1'b1, 16'h0f0f); // subtraction overflow R4
    idle(2);
    drive(16'h1234, 16'h4321, 1'b0, 16'ha5a5);
    idle(1);
    for (int i = 0; i < 300; i++) begin
      drive(16'($urandom), 16'($urandom), 1'($urandom), 16'($urandom));
      if (i % 7 == 0) idle(1 + (i % 3));
    end
    idle(4);
    check("R1 queue drained", 16'(exp_sum_q.size()), 16'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule